// File: doc/BRIEF.md
# Raster Display Timing Generator

This block produces the horizontal sync, vertical sync and data-enable strobes for a raster display, along with the current horizontal and vertical counter values and the position inside the visible window. Each axis is programmed with four cumulative boundaries rather than separate porch widths. Each boundary is the sum of all preceding intervals, minus one where noted: the end of the sync pulse, the end of the back porch, the end of the visible region, and the last count of the line or frame. One counter runs per axis. The horizontal counter steps on every enabled clock. The vertical counter steps once for each horizontal wrap.

Four polarity controls set the active level of horizontal sync, vertical sync and data enable, and pass a pixel-clock inversion select to the clock pad logic. A line-compare value raises a single-cycle pulse at the start of the selected line. Programming that value to the visible-region boundary plus one gives an event right after the last visible line. The current line number is brought out so that software can work out the scan-out position. Clearing the enable parks both counters at zero and drives every strobe to its inactive level.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is held and after it is released with enable low, h_pos and line_no read 0, line_irq is 0, and each of hsync, vsync and de sits at its inactive level.
- R2: While enable is high, h_pos increases by one every clock. In the cycle after h_pos equals h_tot_lim it returns to 0, so a line lasts h_tot_lim+1 clocks.
- R3: line_no increases by one only in the cycle after h_pos wraps, and otherwise holds. A wrap taken while line_no equals v_tot_lim returns it to 0. line_no is the current line number.
- R4: The horizontal sync is active while h_pos <= h_sync_lim. The vertical sync is active while line_no <= v_sync_lim.
- R5: de is active only when h_bp_lim < h_pos <= h_act_lim and v_bp_lim < line_no <= v_act_lim both hold.
- R6: pol_ctl[3] set makes hsync active-high, pol_ctl[2] does the same for vsync, and pol_ctl[1] for de. When a bit is clear the output is active-low, so its inactive level is 1. pclk_inv equals pol_ctl[0].
- R7: line_irq is a one-cycle pulse in each cycle where enable is high, h_pos is 0 and line_no equals line_cmp. With line_cmp = v_act_lim+1 it fires at the start of the first line after the visible region.
- R8: While enable is low, hsync, vsync and de sit at their inactive levels in the same cycle and line_irq is 0. One clock later both counters read 0, and generation restarts from position (0,0).
- R9: act_x equals h_pos-h_bp_lim-1 while h_bp_lim < h_pos <= h_act_lim, and 0 otherwise. act_y is formed the same way from line_no and the vertical limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global run control |
| pol_ctl | input | 4 | Polarity: [3] hsync high, [2] vsync high, [1] de high, [0] pixel clock invert |
| h_sync_lim | input | CNT_W | Horizontal sync length minus one |
| h_bp_lim | input | CNT_W | Horizontal sync plus back porch minus one |
| h_act_lim | input | CNT_W | h_bp_lim plus visible width |
| h_tot_lim | input | CNT_W | Line length minus one |
| v_sync_lim | input | CNT_W | Vertical sync length minus one |
| v_bp_lim | input | CNT_W | Vertical sync plus back porch minus one |
| v_act_lim | input | CNT_W | v_bp_lim plus visible height |
| v_tot_lim | input | CNT_W | Frame length in lines minus one |
| line_cmp | input | CNT_W | Line number that raises line_irq |
| hsync | output | 1 | Horizontal sync, polarity applied |
| vsync | output | 1 | Vertical sync, polarity applied |
| de | output | 1 | Data enable, polarity applied |
| pclk_inv | output | 1 | Pixel clock inversion select |
| h_pos | output | CNT_W | Horizontal counter |
| line_no | output | CNT_W | Vertical counter (current line) |
| act_x | output | CNT_W | Column inside the visible window |
| act_y | output | CNT_W | Row inside the visible window |
| line_irq | output | 1 | Line-compare pulse |

## Verification
The assertions check the counter stepping rules on every cycle: the horizontal step and wrap, the vertical counter holding between wraps, the return to zero while disabled, and the width and gating of the line pulse. The bench alone can show that the sync and data-enable windows fall on the right counts for many randomly drawn limit sets and all polarity combinations. The same holds for the visible-window coordinates, for the line pulse landing on the programmed line (including the line just after the visible region), and for a restart from zero after enable drops in the middle of a frame.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
   // polarity control bit positions inside pol_ctl
   localparam int POL_HS  = 3;
   localparam int POL_VS  = 2;
   localparam int POL_DE  = 1;
   localparam int POL_CLK = 0;
   localparam int N_AXES  = 2;

   typedef enum logic {AX_H = 1'b0, AX_V = 1'b1} axis_e;

   // apply polarity: active-high when hi is set, else active-low
   function automatic logic pol_apply(input logic active, input logic hi);
      return hi ? active : ~active;
   endfunction
endpackage

// File: rtl/rtg_axis_ctr.sv
module rtg_axis_ctr #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             step,
   input  logic [CNT_W-1:0] tot_lim,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   logic [CNT_W-1:0] cnt_q;

   assign wrap = en && step && (cnt_q >= tot_lim);
   assign cnt  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cnt_q <= '0;
      else if (!en)    cnt_q <= '0;
      else if (wrap)   cnt_q <= '0;
      else if (step)   cnt_q <= cnt_q + 1'b1;
   end

   AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (en && step && cnt_q >= tot_lim) |=> (cnt_q == '0)); // R2
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (en && step && cnt_q < tot_lim) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R2
   AST_PARK_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> (cnt_q == '0)); // R8
endmodule

// File: rtl/rtg_axis_decode.sv
module rtg_axis_decode #(
   parameter int CNT_W = 12
) (
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] sync_lim,
   input  logic [CNT_W-1:0] bp_lim,
   input  logic [CNT_W-1:0] act_lim,
   output logic             in_sync,
   output logic             in_act,
   output logic [CNT_W-1:0] act_pos
);
   always_comb begin
      in_sync = (cnt <= sync_lim);
      in_act  = (cnt > bp_lim) && (cnt <= act_lim);
      act_pos = in_act ? (cnt - bp_lim - 1'b1) : '0;
   end
endmodule

// File: rtl/rtg_line_event.sv
module rtg_line_event #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] h_cnt,
   input  logic [CNT_W-1:0] v_cnt,
   input  logic [CNT_W-1:0] cmp,
   input  logic [CNT_W-1:0] h_tot,
   output logic             pulse
);
   assign pulse = en && (h_cnt == '0) && (v_cnt == cmp);

   AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse && h_tot != '0) |=> !pulse); // R7
   AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !en |-> !pulse); // R8
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [3:0]       pol_ctl,
   input  logic [CNT_W-1:0] h_sync_lim,
   input  logic [CNT_W-1:0] h_bp_lim,
   input  logic [CNT_W-1:0] h_act_lim,
   input  logic [CNT_W-1:0] h_tot_lim,
   input  logic [CNT_W-1:0] v_sync_lim,
   input  logic [CNT_W-1:0] v_bp_lim,
   input  logic [CNT_W-1:0] v_act_lim,
   input  logic [CNT_W-1:0] v_tot_lim,
   input  logic [CNT_W-1:0] line_cmp,
   output logic             hsync,
   output logic             vsync,
   output logic             de,
   output logic             pclk_inv,
   output logic [CNT_W-1:0] h_pos,
   output logic [CNT_W-1:0] line_no,
   output logic [CNT_W-1:0] act_x,
   output logic [CNT_W-1:0] act_y,
   output logic             line_irq
);
   import rtg_pkg::*;

   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_width
      $error("raster_timing_gen: CNT_W must lie in 2..16");
   end

   logic [CNT_W-1:0] sync_a [N_AXES];
   logic [CNT_W-1:0] bp_a   [N_AXES];
   logic [CNT_W-1:0] act_a  [N_AXES];
   logic [CNT_W-1:0] tot_a  [N_AXES];
   logic [CNT_W-1:0] cnt_a  [N_AXES];
   logic [CNT_W-1:0] pos_a  [N_AXES];
   logic             step_a [N_AXES];
   logic             wrap_a [N_AXES];
   logic             sync_on[N_AXES];
   logic             act_on [N_AXES];

   assign sync_a[AX_H] = h_sync_lim;  assign sync_a[AX_V] = v_sync_lim;
   assign bp_a[AX_H]   = h_bp_lim;    assign bp_a[AX_V]   = v_bp_lim;
   assign act_a[AX_H]  = h_act_lim;   assign act_a[AX_V]  = v_act_lim;
   assign tot_a[AX_H]  = h_tot_lim;   assign tot_a[AX_V]  = v_tot_lim;
   assign step_a[AX_H] = 1'b1;
   assign step_a[AX_V] = wrap_a[AX_H];

   for (genvar ax = 0; ax < N_AXES; ax++) begin : g_axis
      rtg_axis_ctr #(.CNT_W(CNT_W)) u_ctr (
         .clk(clk), .rst_n(rst_n), .en(enable), .step(step_a[ax]),
         .tot_lim(tot_a[ax]), .cnt(cnt_a[ax]), .wrap(wrap_a[ax])
      );
      rtg_axis_decode #(.CNT_W(CNT_W)) u_dec (
         .cnt(cnt_a[ax]), .sync_lim(sync_a[ax]), .bp_lim(bp_a[ax]),
         .act_lim(act_a[ax]), .in_sync(sync_on[ax]), .in_act(act_on[ax]),
         .act_pos(pos_a[ax])
      );
   end

   rtg_line_event #(.CNT_W(CNT_W)) u_line (
      .clk(clk), .rst_n(rst_n), .en(enable), .h_cnt(cnt_a[AX_H]),
      .v_cnt(cnt_a[AX_V]), .cmp(line_cmp), .h_tot(h_tot_lim), .pulse(line_irq)
   );

   always_comb begin
      hsync    = pol_apply(enable && sync_on[AX_H], pol_ctl[POL_HS]);
      vsync    = pol_apply(enable && sync_on[AX_V], pol_ctl[POL_VS]);
      de       = pol_apply(enable && act_on[AX_H] && act_on[AX_V], pol_ctl[POL_DE]);
      pclk_inv = pol_ctl[POL_CLK];
      h_pos    = cnt_a[AX_H];
      line_no  = cnt_a[AX_V];
      act_x    = pos_a[AX_H];
      act_y    = pos_a[AX_V];
   end

   AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !(h_pos >= h_tot_lim)) |=> (line_no == $past(line_no))); // R3
   AST_LINE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && h_pos >= h_tot_lim && line_no < v_tot_lim) |=> (line_no == $past(line_no) + 1'b1)); // R3
   AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> (hsync == ~pol_ctl[POL_HS] && vsync == ~pol_ctl[POL_VS] && de == ~pol_ctl[POL_DE])); // R8
endmodule

// File: tb/tb_raster_timing_gen.sv
module tb_raster_timing_gen;
   localparam int W = 12;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic rst_n, enable;
   logic [3:0] pol_ctl;
   logic [W-1:0] hs, hb, ha, ht, vs, vb, va, vt, lc;
   logic hsync, vsync, de, pclk_inv, line_irq;
   logic [W-1:0] h_pos, line_no, act_x, act_y;

   raster_timing_gen #(.CNT_W(W)) dut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .pol_ctl(pol_ctl),
      .h_sync_lim(hs), .h_bp_lim(hb), .h_act_lim(ha), .h_tot_lim(ht),
      .v_sync_lim(vs), .v_bp_lim(vb), .v_act_lim(va), .v_tot_lim(vt),
      .line_cmp(lc), .hsync(hsync), .vsync(vsync), .de(de), .pclk_inv(pclk_inv),
      .h_pos(h_pos), .line_no(line_no), .act_x(act_x), .act_y(act_y),
      .line_irq(line_irq)
   );

   int checks = 0, errors = 0;
   int mh = 0, mv = 0;
   int irq_seen = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic bit drive_lvl(input bit active, input bit hi);
      return hi ? active : !active;
   endfunction

   function automatic int win_pos(input int c, input int bp, input int act);
      return (c > bp && c <= act) ? c - bp - 1 : 0;
   endfunction

   task automatic compare_all();
      bit hin, vin, ex_irq;
      hin = (mh > hb) && (mh <= ha);
      vin = (mv > vb) && (mv <= va);
      ex_irq = enable && mh == 0 && mv == lc;
      if (ex_irq) irq_seen++;
      chk(h_pos == W'(mh), "R2", "h_pos", h_pos, mh);
      chk(line_no == W'(mv), "R3", "line_no", line_no, mv);
      chk(hsync == drive_lvl(enable && mh <= hs, pol_ctl[3]), "R4 R6", "hsync", hsync,
          drive_lvl(enable && mh <= hs, pol_ctl[3]));
      chk(vsync == drive_lvl(enable && mv <= vs, pol_ctl[2]), "R4 R6", "vsync", vsync,
          drive_lvl(enable && mv <= vs, pol_ctl[2]));
      chk(de == drive_lvl(enable && hin && vin, pol_ctl[1]), "R5 R6", "de", de,
          drive_lvl(enable && hin && vin, pol_ctl[1]));
      chk(pclk_inv == pol_ctl[0], "R6", "pclk_inv", pclk_inv, pol_ctl[0]);
      chk(line_irq == ex_irq, "R7", "line_irq", line_irq, ex_irq);
      chk(act_x == W'(win_pos(mh, hb, ha)), "R9", "act_x", act_x, win_pos(mh, hb, ha));
      chk(act_y == W'(win_pos(mv, vb, va)), "R9", "act_y", act_y, win_pos(mv, vb, va));
   endtask

   // advance one clock: model follows the inputs held across the edge
   task automatic tick();
      @(posedge clk);
      if (!enable) begin
         mh = 0; mv = 0;
      end else if (mh >= ht) begin
         mh = 0;
         mv = (mv >= vt) ? 0 : mv + 1;
      end else begin
         mh = mh + 1;
      end
      @(negedge clk);
      compare_all();
   endtask

   task automatic rand_cfg();
      hs = W'($urandom_range(0, 2));
      hb = hs + W'($urandom_range(1, 3));
      ha = hb + W'($urandom_range(1, 6));
      ht = ha + W'($urandom_range(1, 3));
      vs = W'($urandom_range(0, 2));
      vb = vs + W'($urandom_range(1, 2));
      va = vb + W'($urandom_range(1, 5));
      vt = va + W'($urandom_range(1, 3));
      lc = W'($urandom_range(0, 32'(vt)));
      pol_ctl = 4'($urandom_range(0, 15));
   endtask

   initial begin
      #(5ns * 150000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      rst_n = 1'b0; enable = 1'b0; pol_ctl = 4'b0000;
      hs = 1; hb = 3; ha = 7; ht = 9; vs = 0; vb = 1; va = 4; vt = 6; lc = 5;
      repeat (3) @(negedge clk);
      // R1: reset state, active-low polarity => inactive level 1
      chk(h_pos == 0 && line_no == 0, "R1", "counters in reset", h_pos + line_no, 0);
      chk(hsync == 1 && vsync == 1 && de == 1, "R1", "strobes in reset",
          {hsync, vsync, de}, 7);
      chk(line_irq == 0, "R1", "irq in reset", line_irq, 0);
      rst_n = 1'b1;
      tick(); tick();

      // directed: line pulse right after last visible line (va+1), R7
      enable = 1'b1; lc = va + 1'b1; pol_ctl = 4'b1110;
      irq_seen = 0;
      repeat (2 * 10 * 7) tick();
      chk(irq_seen == 2, "R7", "pulses after visible region", irq_seen, 2);

      // directed: drop enable mid-frame, R8
      repeat (23) tick();
      enable = 1'b0;
      @(negedge clk);
      chk(hsync == ~pol_ctl[3] && vsync == ~pol_ctl[2] && de == ~pol_ctl[1],
          "R8", "inactive in disable cycle", {hsync, vsync, de}, {~pol_ctl[3], ~pol_ctl[2], ~pol_ctl[1]});
      chk(line_irq == 0, "R8", "no irq while off", line_irq, 0);
      tick();
      chk(h_pos == 0 && line_no == 0, "R8", "counters parked", h_pos + line_no, 0);
      enable = 1'b1;
      tick();

      // random configurations, each run for a few frames with rare enable drops
      for (int cfg = 0; cfg < 12; cfg++) begin
         enable = 1'b0;
         rand_cfg();
         tick();
         enable = 1'b1;
         for (int c = 0; c < 3 * (int'(ht) + 1) * (int'(vt) + 1); c++) begin
            if ($urandom_range(0, 199) == 0) enable = 1'b0;
            else enable = 1'b1;
            tick();
         end
      end

      // extremes: one-pixel line and one-line frame
      enable = 1'b0;
      hs = 0; hb = 0; ha = 0; ht = 0; vs = 0; vb = 0; va = 0; vt = 0; lc = 0;
      pol_ctl = 4'b1111;
      tick();
      enable = 1'b1;
      repeat (8) tick();

      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule